// File: doc/BRIEF.md
# NAND Flash Host Controller

This block connects a simple request/acknowledge register bus to an 8-bit NAND flash device. Software sees three byte-wide registers: a data window, a mode register and a status register. The mode register decides what a data-window access turns into. It can become a command cycle with the command latch line raised, an address cycle with the address latch line raised, or a plain data transfer. A data read can also return the next byte of the error-check code that the block has built up.

While a data mode with accumulation enabled is active, every transferred byte folds into a line-parity word and a column-parity word. Software later reads these as six bytes through the data window and compares them against stored values to find and fix bit errors. Each flash read or write strobe is held low for a fixed number of clocks, and the bus access stalls until that strobe has completed. The status register reports the flash busy flag, so software can poll between pages. In sequential reading it can then keep reading data without reissuing command and address cycles.

Top module: `nand_host_ctrl`

## Requirements
- R1: After reset both flash strobes are high, chip enable is inactive (`nfCeN` = 1), both latch lines are low, `busAck` is low and the mode register reads 0x00.
- R2: Mode register bit 0 drives `nfCle`, bit 1 drives `nfAle` and bit 4 drives chip enable active (`nfCeN` = 0). The register reads back the last value written. It sits at offset 0x4, the data window at 0x0 and status at 0x8.
- R3: A bus write to the data window pulls `nfWeN` low for exactly `STROBE_CYC` cycles, with `nfDout` carrying the written byte and `nfDoe` high for those same cycles. The latch lines follow the mode register throughout.
- R4: A data-window read outside ECC readout pulls `nfReN` low for exactly `STROBE_CYC` cycles and returns the byte present on `nfDin` in the last strobe cycle. `nfWeN` and `nfReN` are never low together.
- R5: Status bit 0 is the busy flag, which is the inverse of `nfRdy` after a two-flop synchroniser. The other status bits read 0.
- R6: ECC accumulates only on data-window transfers while mode bit 5 is set and bits 0 and 1 are clear. Transfers in plain data mode (0x10) or in command/address mode leave the ECC unchanged.
- R7: Any mode write with bit 5 set clears the line parity, the column parity, the byte index and the readout pointer. A readout straight after the clear gives 0x00, 0x00, 0x03, 0x00, 0x00, 0x03.
- R8: For the byte with index i and byte parity p, line-parity bit 2k+1 toggles by p when bit k of i is 1, and bit 2k toggles when it is 0 (k = 0..15). Column bit 2j+1 collects the XOR of the data bits whose position has bit j set, and bit 2j collects those with bit j clear (j = 0..2). Even-index bytes feed column bits 5:0 and odd-index bytes feed bits 11:6.
- R9: While mode bit 6 is set (0x50 or 0xD0), data-window reads return ECC bytes in the order line[7:0], line[15:8], {col[5:0],2'b11}, line[23:16], line[31:24], {col[11:6],2'b11}. These reads produce no flash strobe and are acknowledged one cycle after the request.
- R10: The readout pointer wraps to the first byte after the sixth read, and it keeps its position across mode writes that leave bit 5 clear.
- R11: `busAck` is a single-cycle pulse. A register access is acknowledged in the cycle after the request is seen. A flash transfer is acknowledged in the cycle after its strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Access request, held until acknowledged |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset: 0x0 data, 0x4 mode, 0x8 status |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid while `busAck` is high |
| busAck | output | 1 | One-cycle access completion |
| nfCeN | output | 1 | Flash chip enable, active low |
| nfCle | output | 1 | Command latch enable |
| nfAle | output | 1 | Address latch enable |
| nfWeN | output | 1 | Write strobe, active low |
| nfReN | output | 1 | Read strobe, active low |
| nfDout | output | 8 | Byte driven toward the flash |
| nfDoe | output | 1 | Output enable for `nfDout` |
| nfDin | input | 8 | Byte from the flash |
| nfRdy | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions assume that a requester keeps `busWr`, `busAddr` and `busWdata` steady from raising `busReq` until it sees `busAck`, and drops `busReq` right after that. They also assume that `nfDin` is stable while the read strobe is low. The directed bench drives every access through one task that follows this rule. Its flash model changes the read byte only on the rising edge of `nfReN`, and it toggles `nfRdy` only between accesses.

// File: rtl/nhc_pkg.sv
package nhc_pkg;

  localparam int IDX_W      = 16;
  localparam int LINE_W     = 2 * IDX_W;
  localparam int BITPOS_W   = 3;
  localparam int COL_HALF_W = 2 * BITPOS_W;
  localparam int COL_W      = 2 * COL_HALF_W;
  localparam int ECC_BYTES  = 6;
  localparam int PTR_W      = $clog2(ECC_BYTES);

  localparam int MB_CLE   = 0;
  localparam int MB_ALE   = 1;
  localparam int MB_CE    = 4;
  localparam int MB_ACCUM = 5;
  localparam int MB_ECCRD = 6;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic modeWe;
    logic capture;
    logic xferDone;
    logic xferWr;
    logic eccAdv;
  } ctrlStrb_t;

  function automatic regSel_e decodeReg(input logic [3:0] addr);
    if (addr[1:0] != 2'b00) return REG_NONE;
    case (addr[3:2])
      2'd0:    return REG_DATA;
      2'd1:    return REG_MODE;
      2'd2:    return REG_STAT;
      default: return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/nhc_ecc.sv
module nhc_ecc
  import nhc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clr,
  input  logic       update,
  input  logic [7:0] byteIn,
  input  logic       adv,
  output logic [7:0] rdByte
);

  logic [LINE_W-1:0]     lineQ, lineNext;
  logic [COL_W-1:0]      colQ, colNext;
  logic [COL_HALF_W-1:0] colPar;
  logic [IDX_W-1:0]      idxQ;
  logic [PTR_W-1:0]      ptrQ;
  logic                  bytePar;

  always_comb begin
    bytePar  = ^byteIn;
    lineNext = lineQ;
    for (int k = 0; k < IDX_W; k++) begin
      if (idxQ[k]) lineNext[2*k+1] = lineQ[2*k+1] ^ bytePar;
      else         lineNext[2*k]   = lineQ[2*k]   ^ bytePar;
    end
    colPar = '0;
    for (int j = 0; j < BITPOS_W; j++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) == 1) colPar[2*j+1] = colPar[2*j+1] ^ byteIn[b];
        else                     colPar[2*j]   = colPar[2*j]   ^ byteIn[b];
      end
    end
    colNext = colQ;
    if (idxQ[0]) colNext[COL_W-1:COL_HALF_W] = colQ[COL_W-1:COL_HALF_W] ^ colPar;
    else         colNext[COL_HALF_W-1:0]     = colQ[COL_HALF_W-1:0] ^ colPar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= '0;
      colQ  <= '0;
      idxQ  <= '0;
      ptrQ  <= '0;
    end else if (clr) begin
      lineQ <= '0;
      colQ  <= '0;
      idxQ  <= '0;
      ptrQ  <= '0;
    end else begin
      if (update) begin
        lineQ <= lineNext;
        colQ  <= colNext;
        idxQ  <= idxQ + 1'b1;
      end
      if (adv) ptrQ <= (ptrQ == PTR_W'(ECC_BYTES-1)) ? '0 : ptrQ + 1'b1;
    end
  end

  always_comb begin
    case (ptrQ)
      3'd0:    rdByte = lineQ[7:0];
      3'd1:    rdByte = lineQ[15:8];
      3'd2:    rdByte = {colQ[5:0], 2'b11};
      3'd3:    rdByte = lineQ[23:16];
      3'd4:    rdByte = lineQ[31:24];
      default: rdByte = {colQ[11:6], 2'b11};
    endcase
  end

  // R7: a clear leaves parity, index and pointer at zero
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (lineQ == '0 && colQ == '0 && idxQ == '0 && ptrQ == '0));

  // R10: pointer stays inside the six readout slots
  p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ < PTR_W'(ECC_BYTES));

  // R10: the sixth read returns the pointer to the first slot
  p_ptr_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (adv && !clr && ptrQ == PTR_W'(ECC_BYTES-1)) |=> (ptrQ == '0));

endmodule

// File: rtl/nhc_control.sv
module nhc_control
  import nhc_pkg::*;
#(
  parameter int STROBE_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReq,
  input  logic       busWr,
  input  logic [3:0] busAddr,
  input  logic       eccRdMode,
  output logic       busAck,
  output logic       nfWeN,
  output logic       nfReN,
  output logic       nfDoe,
  output ctrlStrb_t  strb
);

  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_ACK} state_e;

  state_e     stateQ;
  logic [CNT_W-1:0] cntQ;
  logic       opWrQ, opModeQ, opEccRdQ;
  logic       lastCnt, isData, eccRead;
  regSel_e    sel;

  always_comb begin
    sel     = decodeReg(busAddr);
    isData  = (sel == REG_DATA);
    eccRead = isData && !busWr && eccRdMode;
    lastCnt = (cntQ == CNT_W'(STROBE_CYC - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      opWrQ    <= 1'b0;
      opModeQ  <= 1'b0;
      opEccRdQ <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (busReq) begin
          opWrQ    <= busWr;
          opModeQ  <= busWr && (sel == REG_MODE);
          opEccRdQ <= eccRead;
          cntQ     <= '0;
          stateQ   <= (isData && !eccRead) ? ST_STROBE : ST_ACK;
        end
        ST_STROBE: begin
          if (lastCnt) stateQ <= ST_ACK;
          else         cntQ   <= cntQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busAck        = (stateQ == ST_ACK);
    nfWeN         = !((stateQ == ST_STROBE) && opWrQ);
    nfReN         = !((stateQ == ST_STROBE) && !opWrQ);
    nfDoe         = (stateQ == ST_STROBE) && opWrQ;
    strb.modeWe   = busAck && opModeQ;
    strb.eccAdv   = busAck && opEccRdQ;
    strb.xferDone = (stateQ == ST_STROBE) && lastCnt;
    strb.capture  = strb.xferDone && !opWrQ;
    strb.xferWr   = opWrQ;
  end

  // R11: acknowledge never lasts two cycles
  p_ack_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R4: the two flash strobes never overlap
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    (nfWeN || nfReN));

  // R3: the end of a write strobe coincides with the acknowledge
  p_ack_follows_we_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nfWeN) |-> busAck);

  // R9: ECC readout goes straight to acknowledge with no read strobe
  p_no_flash_on_ecc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && busReq && eccRead) |=> (nfReN && busAck));

endmodule

// File: rtl/nhc_datapath.sv
module nhc_datapath
  import nhc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrb_t  strb,
  input  logic [3:0] busAddr,
  input  logic [7:0] busWdata,
  input  logic [7:0] nfDin,
  input  logic       nfRdy,
  output logic [7:0] busRdata,
  output logic       eccRdMode,
  output logic       nfCle,
  output logic       nfAle,
  output logic       nfCeN,
  output logic [7:0] nfDout
);

  logic [7:0] modeQ, rdLatchQ, eccByte;
  logic [1:0] busySyncQ;
  logic       eccClr, eccUpd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= '0;
      rdLatchQ  <= '0;
      busySyncQ <= '0;
    end else begin
      busySyncQ <= {busySyncQ[0], !nfRdy};
      if (strb.modeWe)  modeQ    <= busWdata;
      if (strb.capture) rdLatchQ <= nfDin;
    end
  end

  always_comb begin
    eccClr    = strb.modeWe && busWdata[MB_ACCUM];
    eccUpd    = strb.xferDone && modeQ[MB_ACCUM] && !modeQ[MB_CLE] && !modeQ[MB_ALE];
    eccRdMode = modeQ[MB_ECCRD];
    nfCle     = modeQ[MB_CLE];
    nfAle     = modeQ[MB_ALE];
    nfCeN     = !modeQ[MB_CE];
    nfDout    = busWdata;
    case (decodeReg(busAddr))
      REG_DATA: busRdata = eccRdMode ? eccByte : rdLatchQ;
      REG_MODE: busRdata = modeQ;
      REG_STAT: busRdata = {7'b0, busySyncQ[1]};
      default:  busRdata = '0;
    endcase
  end

  nhc_ecc u_ecc (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (eccClr),
    .update (eccUpd),
    .byteIn (strb.xferWr ? busWdata : nfDin),
    .adv    (strb.eccAdv),
    .rdByte (eccByte)
  );

  // R2: mode only changes through a mode-register write
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.modeWe |=> $stable(modeQ));

  // R6: a transfer without accumulation leaves the readout byte alone
  p_plain_keeps_ecc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xferDone && !modeQ[MB_ACCUM]) |=> $stable(eccByte));

endmodule

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
  import nhc_pkg::*;
#(
  parameter int STROBE_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReq,
  input  logic       busWr,
  input  logic [3:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       busAck,
  output logic       nfCeN,
  output logic       nfCle,
  output logic       nfAle,
  output logic       nfWeN,
  output logic       nfReN,
  output logic [7:0] nfDout,
  output logic       nfDoe,
  input  logic [7:0] nfDin,
  input  logic       nfRdy
);

  ctrlStrb_t strb;
  logic      eccRdMode;

  nhc_control #(.STROBE_CYC(STROBE_CYC)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .busReq    (busReq),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .eccRdMode (eccRdMode),
    .busAck    (busAck),
    .nfWeN     (nfWeN),
    .nfReN     (nfReN),
    .nfDoe     (nfDoe),
    .strb      (strb)
  );

  nhc_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .nfDin     (nfDin),
    .nfRdy     (nfRdy),
    .busRdata  (busRdata),
    .eccRdMode (eccRdMode),
    .nfCle     (nfCle),
    .nfAle     (nfAle),
    .nfCeN     (nfCeN),
    .nfDout    (nfDout)
  );

endmodule

// File: tb/test_nand_host_ctrl.sv
`timescale 1ns/1ps
module test_nand_host_ctrl;

  localparam int SC = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReq = 1'b0, busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       busAck, nfCeN, nfCle, nfAle, nfWeN, nfReN, nfDoe;
  logic [7:0] nfDout, nfDin;
  logic       nfRdy = 1'b1;

  int checks = 0, fails = 0;
  int weLow, reLow, doeCyc, lat;
  bit armed = 0;

  logic [7:0] rdMem [8];
  int         rdIdx = 0;
  logic [7:0] logDat [16];
  logic       logCle [16];
  logic       logAle [16];
  int         logN = 0;

  logic [31:0] mLine;
  logic [11:0] mCol;
  logic [15:0] mIdx;
  logic [7:0]  expEcc [6];

  always #5 clk = ~clk;

  nand_host_ctrl #(.STROBE_CYC(SC)) i_nand_host_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .nfCeN(nfCeN),
    .nfCle(nfCle), .nfAle(nfAle), .nfWeN(nfWeN), .nfReN(nfReN), .nfDout(nfDout),
    .nfDoe(nfDoe), .nfDin(nfDin), .nfRdy(nfRdy)
  );

  // flash model: byte changes after each read strobe, write cycles are logged
  assign nfDin = rdMem[rdIdx[2:0]];
  always @(posedge nfReN) if (armed) rdIdx = rdIdx + 1;
  always @(posedge nfWeN) if (armed && logN < 16) begin
    logDat[logN] = nfDout; logCle[logN] = nfCle; logAle[logN] = nfAle; logN = logN + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic busXfer(input logic wr, input logic [3:0] addr, input logic [7:0] wd,
                         output logic [7:0] rd);
    @(negedge clk);
    busReq = 1'b1; busWr = wr; busAddr = addr; busWdata = wd;
    weLow = 0; reLow = 0; doeCyc = 0; lat = 0; rd = '0;
    forever begin
      @(negedge clk);
      lat++;
      if (!nfWeN) weLow++;
      if (!nfReN) reLow++;
      if (nfDoe)  doeCyc++;
      if (busAck) begin rd = busRdata; break; end
      if (lat > 200) begin
        check(1'b0, "watchdog: access never acknowledged", lat, 0);
        summary();
      end
    end
    busReq = 1'b0;
    @(negedge clk);
    check(busAck == 1'b0, "R11 ack lasts one cycle", busAck, 0);
  endtask

  task automatic regWr(input logic [3:0] addr, input logic [7:0] v);
    logic [7:0] dummy;
    busXfer(1'b1, addr, v, dummy);
  endtask

  task automatic regRd(input logic [3:0] addr, output logic [7:0] v);
    busXfer(1'b0, addr, 8'h00, v);
  endtask

  // reference ECC built from R8
  task automatic modelClear();
    mLine = '0; mCol = '0; mIdx = '0;
  endtask

  task automatic modelByte(input logic [7:0] d);
    logic p;
    p = ^d;
    for (int k = 0; k < 16; k++)
      if (mIdx[k]) mLine[2*k+1] ^= p; else mLine[2*k] ^= p;
    for (int b = 0; b < 8; b++)
      for (int j = 0; j < 3; j++) begin
        int pos;
        pos = (mIdx[0] ? 6 : 0) + 2*j + (((b >> j) & 1) == 1 ? 1 : 0);
        mCol[pos] ^= d[b];
      end
    mIdx++;
  endtask

  task automatic modelExpect();
    expEcc[0] = mLine[7:0];   expEcc[1] = mLine[15:8];  expEcc[2] = {mCol[5:0], 2'b11};
    expEcc[3] = mLine[23:16]; expEcc[4] = mLine[31:24]; expEcc[5] = {mCol[11:6], 2'b11};
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(nfWeN && nfReN, "R1 strobes idle high", {nfWeN, nfReN}, 2'b11);
    check(nfCeN == 1'b1 && !nfCle && !nfAle, "R1 chip/latch idle", {nfCeN, nfCle, nfAle}, 3'b100);
    check(busAck == 1'b0, "R1 no ack after reset", busAck, 0);
    regRd(4'h4, v);
    check(v == 8'h00, "R1 mode reads zero", v, 0);
    check(lat == 1, "R11 register access latency", lat, 1);
    regRd(4'h8, v);
    check(v == 8'h00, "R5 status idle with ready high", v, 0);
  endtask

  task automatic t_modePins();
    logic [7:0] v;
    regWr(4'h4, 8'h11);
    check(nfCle && !nfAle && !nfCeN, "R2 command mode pins", {nfCle, nfAle, nfCeN}, 3'b100);
    regRd(4'h4, v);
    check(v == 8'h11, "R2 mode readback", v, 8'h11);
    regWr(4'h4, 8'h12);
    check(!nfCle && nfAle && !nfCeN, "R2 address mode pins", {nfCle, nfAle, nfCeN}, 3'b010);
  endtask

  task automatic t_idRead();
    logic [7:0] v;
    logN = 0;
    regWr(4'h4, 8'h11);
    regWr(4'h0, 8'h90);
    check(weLow == SC, "R3 write strobe width", weLow, SC);
    check(doeCyc == SC, "R3 output enable width", doeCyc, SC);
    check(reLow == 0, "R4 no read strobe on write", reLow, 0);
    check(lat == SC + 1, "R11 flash write latency", lat, SC + 1);
    check(logN == 1 && logDat[0] == 8'h90 && logCle[0] && !logAle[0],
          "R3 command cycle on flash", logDat[0], 8'h90);
    regWr(4'h4, 8'h12);
    regWr(4'h0, 8'h00);
    check(logN == 2 && logDat[1] == 8'h00 && logAle[1] && !logCle[1],
          "R3 address cycle on flash", {logAle[1], logCle[1]}, 2'b10);
    regWr(4'h4, 8'h10);
    rdMem[0] = 8'h98; rdMem[1] = 8'hDC; rdIdx = 0;
    regRd(4'h0, v);
    check(v == 8'h98, "R4 first ID byte", v, 8'h98);
    check(reLow == SC && weLow == 0, "R4 read strobe width", reLow, SC);
    regRd(4'h0, v);
    check(v == 8'hDC, "R4 second ID byte", v, 8'hDC);
  endtask

  task automatic t_status();
    logic [7:0] v;
    nfRdy = 1'b0;
    repeat (3) @(negedge clk);
    regRd(4'h8, v);
    check(v == 8'h01, "R5 busy flag set", v, 1);
    nfRdy = 1'b1;
    repeat (3) @(negedge clk);
    regRd(4'h8, v);
    check(v == 8'h00, "R5 busy flag clear", v, 0);
  endtask

  task automatic t_eccRead();
    logic [7:0] v;
    regWr(4'h4, 8'h30);
    modelClear();
    rdMem[0] = 8'h5A; rdMem[1] = 8'h01; rdMem[2] = 8'hFF; rdMem[3] = 8'h3C; rdIdx = 0;
    for (int i = 0; i < 4; i++) begin
      regRd(4'h0, v);
      check(v == rdMem[i], "R4 page byte", v, rdMem[i]);
      modelByte(v);
    end
    modelExpect();
    regWr(4'h4, 8'h50);
    for (int i = 0; i < 6; i++) begin
      regRd(4'h0, v);
      check(v == expEcc[i], "R8 R9 ECC readout byte", v, expEcc[i]);
      check(reLow == 0 && lat == 1, "R9 readout without flash strobe", reLow, 0);
    end
    regRd(4'h0, v);
    check(v == expEcc[0], "R10 pointer wraps to first byte", v, expEcc[0]);
    regWr(4'h4, 8'h10);
    rdMem[4] = 8'hA5; rdMem[5] = 8'h77;
    regRd(4'h0, v);
    regRd(4'h0, v);
    regWr(4'h4, 8'h50);
    for (int i = 1; i < 6; i++) begin
      regRd(4'h0, v);
      check(v == expEcc[i], "R6 R10 plain data leaves ECC, pointer kept", v, expEcc[i]);
    end
  endtask

  task automatic t_eccWrite();
    logic [7:0] v;
    logic [7:0] wb [3];
    regRd(4'h0, v);
    regRd(4'h0, v);
    regWr(4'h4, 8'hB0);
    modelClear();
    regWr(4'h4, 8'hD0);
    for (int i = 0; i < 6; i++) begin
      regRd(4'h0, v);
      check(v == ((i == 2 || i == 5) ? 8'h03 : 8'h00), "R7 cleared readout", v,
            (i == 2 || i == 5) ? 8'h03 : 8'h00);
    end
    wb[0] = 8'h81; wb[1] = 8'h7E; wb[2] = 8'h10;
    regWr(4'h4, 8'hB0);
    for (int i = 0; i < 3; i++) begin
      regWr(4'h0, wb[i]);
      modelByte(wb[i]);
    end
    modelExpect();
    regWr(4'h4, 8'hD0);
    for (int i = 0; i < 6; i++) begin
      regRd(4'h0, v);
      check(v == expEcc[i], "R8 write-path ECC byte", v, expEcc[i]);
    end
  endtask

  task automatic t_cleNoEcc();
    logic [7:0] v;
    regWr(4'h4, 8'h31);
    regWr(4'h0, 8'h77);
    regWr(4'h4, 8'h32);
    regWr(4'h0, 8'h3E);
    regWr(4'h4, 8'h50);
    regRd(4'h0, v);
    check(v == 8'h00, "R6 command/address cycles not accumulated", v, 0);
    regRd(4'h0, v);
    regRd(4'h0, v);
    check(v == 8'h03, "R6 column parity untouched", v, 8'h03);
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog: run did not finish", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) rdMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    armed = 1;
    @(negedge clk);
    t_reset();
    t_modePins();
    t_idRead();
    t_status();
    t_eccRead();
    t_eccWrite();
    t_cleNoEcc();
    summary();
  end

endmodule